// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a virtual address when the translation cache has missed. It accepts one walk at a time, made up of a virtual address, an access kind and the page number of the top-level table, which comes from the base register. It then fetches four 64-bit table entries in dependent order. Each fetch is addressed by the table base taken from the previous entry, plus a 9-bit slice of the virtual page number. The slices are used from the most significant down.

A walk ends in one of three ways. It stops with a not-present fault at the first entry whose present bit is clear. It stops with a protection fault when the final entry does not allow the requested access. Otherwise it returns the final entry with its accessed flag set, and with its dirty flag set as well for a write. When either flag changes value, the updated entry is written back to memory before the response. A faulting walk also captures its virtual address in a holding register that keeps its value until the next fault.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o, mem_rd_valid_o and mem_wr_valid_o are 0, and fault_va_o is 0.
- R2: The read for level k (k = 0..3) targets {table_ppn, vpn[(3-k)*9 +: 9], 3'b000}, where vpn is req_va_i[47:12]. The mem_rd_addr_o value stays stable while mem_rd_valid_o is high and mem_rd_ready_i is low.
- R3: The level-0 table page number is the value on root_ppn_i in the cycle the request is accepted.
- R4: For levels 1..3, the table page number is taken from bits PA_W-1:12 of the previous entry. Entry bits 62:PA_W are ignored for this purpose.
- R5: An entry with bit 0 (present) equal to 0, at any level, ends the walk. The response then has resp_fault_o=1 and resp_cause_o=1, no further read is issued, and no write is issued.
- R6: At the final level, the access code on req_acc_i is interpreted as 0 = read, 1 = write, 2 = execute, with 3 treated as read. A write to an entry with bit 1 clear, or an execute of an entry with bit 63 set, ends the walk with resp_cause_o=2 and no write. A read is always permitted.
- R7: On every fault, fault_va_o takes the full virtual address of that walk. fault_va_o changes at no other time.
- R8: A successful walk returns resp_fault_o=0 and resp_cause_o=0. resp_pte_o equals the final entry with bit 5 (accessed) set and, for a write, bit 6 (dirty) set.
- R9: The updated final entry is written to the final entry's address exactly when it differs from the entry that was read. Otherwise no write is issued. The write's address and data stay stable while mem_wr_ready_i is low.
- R10: Only one walk is in flight. req_ready_o is 0 from acceptance until the response. resp_valid_o is a one-cycle pulse, after which req_ready_o is 1 again.
- R11: The read and write request ports are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request accepted when both high |
| req_va_i | input | VA_W | Virtual address to translate |
| req_acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 read |
| root_ppn_i | input | PA_W-12 | Page number of the top-level table |
| mem_rd_valid_o | output | 1 | Entry read request |
| mem_rd_ready_i | input | 1 | Read request taken |
| mem_rd_addr_o | output | PA_W | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| mem_wr_valid_o | output | 1 | Entry write-back request |
| mem_wr_ready_i | input | 1 | Write taken |
| mem_wr_addr_o | output | PA_W | Byte address of the write-back |
| mem_wr_data_o | output | 64 | Updated entry |
| resp_valid_o | output | 1 | Walk result pulse |
| resp_pte_o | output | 64 | Final entry after status update |
| resp_fault_o | output | 1 | Walk ended in a fault |
| resp_cause_o | output | 2 | 0 none, 1 not present, 2 protection |
| fault_va_o | output | VA_W | Virtual address of the most recent fault |

## Verification
The bench builds the walker with VA_W=48 and PA_W=40. With that width, the junk the bench places in entry bits 51:40 must be dropped when a table page number is formed. The bench also places a top-level table near the top of the 40-bit range. It stops a walk with a not-present entry at each of the four levels, under every access code. At the leaf it covers all 64 combinations of access code, writable bit, no-execute bit and prior accessed/dirty state, which reaches every protection outcome and every write-back decision. The page-number slices alternate between all zeros, all ones and mixed values. Memory stalls and response latency shift from walk to walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR,
    ST_DONE
  } walk_state_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] CAUSE_NONE        = 2'd0;
  localparam logic [1:0] CAUSE_NOT_PRESENT = 2'd1;
  localparam logic [1:0] CAUSE_PROT        = 2'd2;

  localparam int PTE_W  = 64;
  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_NX = 63;
endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
  parameter int PPN_W  = 40,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int VPN_W  = LEVELS * IDX_W,
  parameter int LVL_W  = $clog2(LEVELS)
) (
  input  logic [PPN_W-1:0]         tbl_ppn_i,
  input  logic [VPN_W-1:0]         vpn_i,
  input  logic [LVL_W-1:0]         level_i,
  output logic [PPN_W+IDX_W+2:0]   entry_addr_o
);
  logic [IDX_W-1:0] idx [LEVELS];

  // level 0 takes the most significant slice
  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign idx[l] = vpn_i[(LEVELS-1-l)*IDX_W +: IDX_W];
  end

  // table base is page aligned and a table fills one page: concatenate, no adder
  assign entry_addr_o = {tbl_ppn_i, idx[level_i], 3'b000};
endmodule

// File: rtl/pt_walker_leaf.sv
module pt_walker_leaf
  import pt_walker_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  logic [1:0]       acc_i,
  output logic             prot_fault_o,
  output logic [PTE_W-1:0] pte_upd_o,
  output logic             changed_o
);
  always_comb begin
    prot_fault_o = ((acc_i == ACC_WRITE) && !pte_i[BIT_W]) ||
                   ((acc_i == ACC_EXEC)  &&  pte_i[BIT_NX]);
    pte_upd_o = pte_i;
    pte_upd_o[BIT_A] = 1'b1;
    if (acc_i == ACC_WRITE) pte_upd_o[BIT_D] = 1'b1;
    changed_o = (pte_upd_o != pte_i);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  localparam int PG_W  = IDX_W + 3,
  localparam int PPN_W = PA_W - PG_W,
  localparam int VPN_W = VA_W - PG_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_acc_i,
  input  logic [PPN_W-1:0]  root_ppn_i,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [PA_W-1:0]   mem_rd_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [PA_W-1:0]   mem_wr_addr_o,
  output logic [63:0]       mem_wr_data_o,
  output logic              resp_valid_o,
  output logic [63:0]       resp_pte_o,
  output logic              resp_fault_o,
  output logic [1:0]        resp_cause_o,
  output logic [VA_W-1:0]   fault_va_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e      state_q;
  logic [LVL_W-1:0] level_q;
  logic [PPN_W-1:0] ppn_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic [63:0]      pte_q;
  logic             fault_q;
  logic [1:0]       cause_q;
  logic [VA_W-1:0]  fault_va_q;

  logic [PA_W-1:0]  entry_addr;
  logic             leaf_prot;
  logic [63:0]      leaf_upd;
  logic             leaf_chg;

  pt_walker_addr #(
    .PPN_W (PPN_W),
    .LEVELS(LEVELS),
    .IDX_W (IDX_W),
    .VPN_W (VPN_W),
    .LVL_W (LVL_W)
  ) u_addr (
    .tbl_ppn_i   (ppn_q),
    .vpn_i       (va_q[VA_W-1:PG_W]),
    .level_i     (level_q),
    .entry_addr_o(entry_addr)
  );

  // evaluated straight off the response so the leaf decision costs no extra cycle
  pt_walker_leaf u_leaf (
    .pte_i       (mem_rsp_data_i),
    .acc_i       (acc_q),
    .prot_fault_o(leaf_prot),
    .pte_upd_o   (leaf_upd),
    .changed_o   (leaf_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      level_q    <= '0;
      ppn_q      <= '0;
      va_q       <= '0;
      acc_q      <= ACC_READ;
      pte_q      <= '0;
      fault_q    <= 1'b0;
      cause_q    <= CAUSE_NONE;
      fault_va_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_va_i;
            acc_q   <= req_acc_i;
            ppn_q   <= root_ppn_i;
            level_q <= '0;
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            state_q <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (mem_rd_ready_i) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rsp_valid_i) begin
            pte_q <= mem_rsp_data_i;
            if (!mem_rsp_data_i[BIT_P]) begin
              fault_q    <= 1'b1;
              cause_q    <= CAUSE_NOT_PRESENT;
              fault_va_q <= va_q;
              state_q    <= ST_DONE;
            end else if (level_q != LAST_LVL) begin
              ppn_q   <= mem_rsp_data_i[PA_W-1:PG_W];
              level_q <= level_q + 1'b1;
              state_q <= ST_RD_REQ;
            end else if (leaf_prot) begin
              fault_q    <= 1'b1;
              cause_q    <= CAUSE_PROT;
              fault_va_q <= va_q;
              state_q    <= ST_DONE;
            end else begin
              pte_q   <= leaf_upd;
              state_q <= leaf_chg ? ST_WR : ST_DONE;
            end
          end
        end
        ST_WR: begin
          if (mem_wr_ready_i) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign mem_rd_valid_o = (state_q == ST_RD_REQ);
  assign mem_rd_addr_o  = entry_addr;
  // level and table base still point at the leaf entry
  assign mem_wr_valid_o = (state_q == ST_WR);
  assign mem_wr_addr_o  = entry_addr;
  assign mem_wr_data_o  = pte_q;
  assign resp_valid_o   = (state_q == ST_DONE);
  assign resp_pte_o     = pte_q;
  assign resp_fault_o   = fault_q;
  assign resp_cause_o   = cause_q;
  assign fault_va_o     = fault_va_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 48,
  parameter int PA_W = 52
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             mem_rd_valid_o,
  input logic             mem_rd_ready_i,
  input logic [PA_W-1:0]  mem_rd_addr_o,
  input logic             mem_wr_valid_o,
  input logic             mem_wr_ready_i,
  input logic [PA_W-1:0]  mem_wr_addr_o,
  input logic [63:0]      mem_wr_data_o,
  input logic             resp_valid_o,
  input logic [63:0]      resp_pte_o,
  input logic             resp_fault_o,
  input logic [1:0]       resp_cause_o,
  input logic [VA_W-1:0]  fault_va_o
);
  p_busy_after_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_resp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (!resp_valid_o && req_ready_o));

  p_ports_exclusive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> (!mem_rd_valid_o && !req_ready_o));

  p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

  p_wr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  p_wr_accessed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> (mem_wr_data_o[5] && mem_wr_data_o[0]));

  p_fault_va_only_on_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fault_va_o) |-> (resp_valid_o && resp_fault_o));

  p_fault_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_cause_o == 2'd1 || resp_cause_o == 2'd2));

  p_success_pte_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_fault_o) |-> (resp_cause_o == 2'd0 && resp_pte_o[5] && resp_pte_o[0]));
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W),
  .PA_W(PA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .mem_rd_valid_o(mem_rd_valid_o),
  .mem_rd_ready_i(mem_rd_ready_i),
  .mem_rd_addr_o (mem_rd_addr_o),
  .mem_wr_valid_o(mem_wr_valid_o),
  .mem_wr_ready_i(mem_wr_ready_i),
  .mem_wr_addr_o (mem_wr_addr_o),
  .mem_wr_data_o (mem_wr_data_o),
  .resp_valid_o  (resp_valid_o),
  .resp_pte_o    (resp_pte_o),
  .resp_fault_o  (resp_fault_o),
  .resp_cause_o  (resp_cause_o),
  .fault_va_o    (fault_va_o)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int VA_W  = 48;
  localparam int PA_W  = 40;
  localparam int PG_W  = 12;
  localparam int PPN_W = PA_W - PG_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [VA_W-1:0]   req_va;
  logic [1:0]        req_acc;
  logic [PPN_W-1:0]  root_ppn;
  logic              mem_rd_valid, mem_rd_ready;
  logic [PA_W-1:0]   mem_rd_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;
  logic              mem_wr_valid, mem_wr_ready;
  logic [PA_W-1:0]   mem_wr_addr;
  logic [63:0]       mem_wr_data;
  logic              resp_valid;
  logic [63:0]       resp_pte;
  logic              resp_fault;
  logic [1:0]        resp_cause;
  logic [VA_W-1:0]   fault_va;

  pt_walker #(.VA_W(VA_W), .PA_W(PA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_acc_i(req_acc), .root_ppn_i(root_ppn),
    .mem_rd_valid_o(mem_rd_valid), .mem_rd_ready_i(mem_rd_ready), .mem_rd_addr_o(mem_rd_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .mem_wr_valid_o(mem_wr_valid), .mem_wr_ready_i(mem_wr_ready),
    .mem_wr_addr_o(mem_wr_addr), .mem_wr_data_o(mem_wr_data),
    .resp_valid_o(resp_valid), .resp_pte_o(resp_pte), .resp_fault_o(resp_fault),
    .resp_cause_o(resp_cause), .fault_va_o(fault_va)
  );

  logic [63:0] mem [logic [PA_W-1:0]];

  // written only by the main process
  int checks = 0;
  int errors = 0;
  int lat_cfg = 0;
  int stall_cfg = 0;
  int rd_start = 0;
  logic [PA_W-1:0] exp_rd [4];
  // written only by the memory responder
  int rd_total = 0;
  int rd_bad = 0;
  int wr_total = 0;
  int cyc = 0;
  logic [PA_W-1:0] wr_addr_seen = '0;
  logic [63:0]     wr_data_seen = '0;

  initial begin : responder
    bit hs, pend;
    int wcnt, k;
    logic [PA_W-1:0] paddr;
    hs = 0; pend = 0; wcnt = 0; paddr = '0;
    mem_rd_ready = 1'b0; mem_wr_ready = 1'b0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (hs) begin hs = 0; pend = 1; wcnt = lat_cfg; end
      if (pend) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 64'h0;
          pend = 0;
        end else wcnt--;
      end
      mem_rd_ready = ((cyc + stall_cfg) % 3) != 0;
      mem_wr_ready = ((cyc + stall_cfg) % 2) == 0;
      if (rst_n && mem_rd_valid && mem_rd_ready) begin
        hs = 1;
        paddr = mem_rd_addr;
        k = rd_total - rd_start;
        if (k > 3) rd_bad++;
        else if (paddr !== exp_rd[k]) rd_bad++;
        rd_total++;
      end
      if (rst_n && mem_wr_valid && mem_wr_ready) begin
        wr_total++;
        wr_addr_seen = mem_wr_addr;
        wr_data_seen = mem_wr_data;
        mem[mem_wr_addr] = mem_wr_data;
      end
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [35:0] vpn_for(input int n);
    case (n % 5)
      0: return '0;
      1: return '1;
      default: return {9'((n*131) % 512), 9'((n*97 + 5) % 512),
                       9'((n*53 + 11) % 512), 9'((n*29 + 200) % 512)};
    endcase
  endfunction

  // builds four tables; np_lvl in 0..3 clears the present bit there, 4 = none
  task automatic build(input logic [PPN_W-1:0] root, input logic [35:0] vpn,
                       input int np_lvl, input logic [63:0] leaf);
    logic [PPN_W-1:0] tb [4];
    logic [63:0] e;
    tb[0] = root;
    tb[1] = 28'h1234567;
    tb[2] = 28'h0000003;
    tb[3] = 28'hABCDEF0;
    mem.delete();
    for (int l = 0; l < 4; l++) begin
      exp_rd[l] = {tb[l], vpn[(3-l)*9 +: 9], 3'b000};
      if (l < 3) e = (64'(tb[l+1]) << 12) | 64'h000A_5000_0000_0000 | 64'h3;
      else       e = leaf;
      if (l == np_lvl) e[0] = 1'b0;
      mem[exp_rd[l]] = e;
    end
  endtask

  logic [VA_W-1:0] last_fva = '0;

  task automatic walk(input int n, input logic [PPN_W-1:0] root, input logic [1:0] acc,
                      input int np_lvl, input logic [63:0] leaf, input string rq);
    logic [35:0] vpn;
    logic [VA_W-1:0] va;
    bit prot, ewr, efault;
    logic [63:0] upd;
    int exp_reads, rd0, wr0, t;
    logic [1:0] ecause;
    vpn = vpn_for(n);
    va = {vpn, 12'((n*29) % 4096)};
    build(root, vpn, np_lvl, leaf);
    lat_cfg = n % 3;
    stall_cfg = n % 6;
    prot = (acc == 2'd1 && !leaf[1]) || (acc == 2'd2 && leaf[63]);
    upd = leaf | 64'h20 | ((acc == 2'd1) ? 64'h40 : 64'h0);
    if (np_lvl < 4) begin
      efault = 1; ecause = 2'd1; exp_reads = np_lvl + 1; ewr = 0;
    end else begin
      efault = prot; ecause = prot ? 2'd2 : 2'd0; exp_reads = 4;
      ewr = !prot && (upd != leaf);
    end
    @(negedge clk);
    rd_start = rd_total;
    rd0 = rd_total;
    wr0 = wr_total;
    root_ppn = root; req_va = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    root_ppn = ~root;
    chk("R10", "ready low while busy", 64'(req_ready), 64'd0);
    t = 0;
    while (!resp_valid && t < 2000) begin @(negedge clk); t++; end
    chk("R10", "response arrives", 64'(resp_valid), 64'd1);
    chk(rq, "fault flag", 64'(resp_fault), 64'(efault));
    chk(rq, "cause", 64'(resp_cause), 64'(ecause));
    if (!efault) chk("R8", "returned entry", resp_pte, upd);
    chk("R2", "read count", 64'(rd_total - rd0), 64'(exp_reads));
    chk("R2", "read addresses (R3 R4)", 64'(rd_bad), 64'd0);
    chk("R9", "write count", 64'(wr_total - wr0), 64'(ewr));
    if (ewr) begin
      chk("R9", "write address", 64'(wr_addr_seen), 64'(exp_rd[3]));
      chk("R9", "write data", wr_data_seen, upd);
    end
    if (efault) last_fva = va;
    chk("R7", "fault address", 64'(fault_va), 64'(last_fva));
    @(negedge clk);
    chk("R10", "single pulse", 64'(resp_valid), 64'd0);
    chk("R10", "ready again", 64'(req_ready), 64'd1);
  endtask

  task automatic run_all();
    int n;
    logic [63:0] leaf;
    logic [PPN_W-1:0] root;
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_acc = '0; root_ppn = '0;
    repeat (3) @(negedge clk);
    chk("R1", "ready", 64'(req_ready), 64'd1);
    chk("R1", "rd valid", 64'(mem_rd_valid), 64'd0);
    chk("R1", "wr valid", 64'(mem_wr_valid), 64'd0);
    chk("R1", "resp valid", 64'(resp_valid), 64'd0);
    chk("R1", "fault va", 64'(fault_va), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n = 0;
    // not-present at each level, every access code
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int acc = 0; acc < 4; acc++) begin
        root = n[0] ? 28'hF000001 : 28'h0000001;
        leaf = 64'h0000_0055_5555_5067;
        walk(n, root, 2'(acc), lvl, leaf, "R5");
        n++;
      end
    end
    // leaf sweep: access code x writable x no-execute x prior A/D
    for (int acc = 0; acc < 4; acc++) begin
      for (int w = 0; w < 2; w++) begin
        for (int nx = 0; nx < 2; nx++) begin
          for (int ad = 0; ad < 4; ad++) begin
            root = n[0] ? 28'hF000001 : 28'h0000001;
            leaf = (64'(nx) << 63) | (64'h5555555 << 12) | 64'h4 |
                   (64'(w) << 1) | (64'(ad) << 5) | 64'h1;
            walk(n, root, 2'(acc), 4,  leaf,
                 ((acc == 1 && w == 0) || (acc == 2 && nx == 1)) ? "R6" : "R8");
            n++;
          end
        end
      end
    end
    // R11 is covered by the bound checker during every walk
  endtask

  initial begin
    bit wd;
    wd = 0;
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wd = 1; end
    join_any
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=complete");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule